// File: doc/BRIEF.md
# Float to Fixed-Point Converter

This block turns an IEEE-754 single-precision operand into a fixed-point integer. The result is 16 or 32 bits wide, signed or unsigned. A 5-bit immediate, delivered as a 4-bit upper part and a 1-bit lower part, sets how many fraction bits the result carries. The operand is scaled by a power of two and cut toward zero. Results that fall outside the chosen range are clamped to the nearest bound. An invalid-operation flag and an inexact flag report what happened.

A conversion is requested by pulsing `in_valid` with the operand and the mode selects. The registered result, its flags and `out_valid` appear on the next clock edge. A new request may be issued every cycle. Outside a strobe the outputs keep their last values.

Top module: `flt2fix_unit`

## Requirements
- R1: The immediate is `{imm_hi, imm_lo}`, where `imm_lo` is the least significant bit. The fraction-bit count is F = B - immediate, with B = 16 when `half_sel`=1 and B = 32 when `half_sel`=0. F can therefore be negative in half mode. The operand is multiplied by 2^F before conversion.
- R2: The scaled value is truncated toward zero. `out_inexact` is 1 exactly when nonzero fraction bits were dropped and no clamp occurred. Denormal inputs are handled in the same way.
- R3: With `sign_sel`=1 and `half_sel`=0, scaled values below -2^31 give 0x80000000 and values above 2^31-1 give 0x7FFFFFFF. Each such clamp sets `out_invalid`.
- R4: With `sign_sel`=1 and `half_sel`=1, the result is limited to -32768..32767, and a clamp sets `out_invalid`. Bits 31:16 of the result repeat bit 15.
- R5: With `sign_sel`=0, any scaled value below zero gives 0 and sets `out_invalid`. This includes values such as -0.5. Negative zero gives 0 with no flag. Values above 2^N-1 give 2^N-1 and set `out_invalid`. In half mode bits 31:16 are zero.
- R6: The range test is made on the scaled value before truncation. A value just beyond a bound, such as 32767.5 in signed half mode, clamps and flags invalid.
- R7: A NaN (exponent all ones, mantissa nonzero) gives 0 with `out_invalid` set. Infinities clamp to the bound matching their sign.
- R8: The flags describe only the current conversion. They are never both set, and nothing carries over from earlier conversions.
- R9: Result, flags and `out_valid` are registered one cycle after `in_valid`. Without a strobe, `out_valid` is 0 and the result and flags hold regardless of the inputs. Reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Conversion request strobe |
| in_float | input | 32 | Single-precision operand |
| sign_sel | input | 1 | 1 = signed result, 0 = unsigned |
| half_sel | input | 1 | 1 = 16-bit result, 0 = 32-bit |
| imm_hi | input | 4 | Upper four bits of the immediate |
| imm_lo | input | 1 | Least significant bit of the immediate |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| out_result | output | 32 | Fixed-point result, extended to 32 bits |
| out_invalid | output | 1 | Clamp or NaN occurred |
| out_inexact | output | 1 | Fraction bits were discarded |

## Verification
The converter is tried with:
- exact small values and values that need truncation, of both signs, which separate truncation from rounding;
- values exactly on a bound, values a fraction beyond it, and values far beyond it, which show whether the range test happens before or after truncation;
- NaN, infinities, denormals, negative zero and tiny negatives in unsigned mode, which exercise the special-value paths;
- the immediate at 0, at 31 and at values that give a zero or negative fraction count in half mode, which show whether it is decoded as width minus immediate.

Back-to-back requests check that flags from one conversion do not leak into the next.

// File: rtl/flt2fix_pkg.sv
`timescale 1ns/1ps
package flt2fix_pkg;
  localparam int FLT_W  = 32;
  localparam int EXP_W  = 8;
  localparam int MAN_W  = 23;
  localparam int IMM_W  = 5;
  localparam int WORD_W = 32;
  localparam int HALF_W = 16;
  localparam int SH_W   = 10;  // signed shift range, covers exponent span plus fraction count
  localparam int MAG_W  = WORD_W + 8;

  typedef struct packed {
    logic             sgn;
    logic             nan;
    logic             huge;     // magnitude certainly beyond every bound
    logic             frac_nz;  // nonzero bits below the binary point
    logic [MAG_W-1:0] mag;      // integer part of |scaled value|
  } scaled_t;
endpackage

// File: rtl/flt2fix_fbits.sv
`timescale 1ns/1ps
module flt2fix_fbits
  import flt2fix_pkg::*;
(
  input  logic                   half_sel,
  input  logic [IMM_W-2:0]       imm_hi,
  input  logic                   imm_lo,
  output logic signed [SH_W-1:0] fbits
);
  logic [IMM_W-1:0] imm;
  logic [SH_W-1:0]  base;

  always_comb begin
    imm   = {imm_hi, imm_lo};
    base  = half_sel ? SH_W'(HALF_W) : SH_W'(WORD_W);
    fbits = $signed(base - SH_W'(imm));
  end
endmodule

// File: rtl/flt2fix_scale.sv
`timescale 1ns/1ps
module flt2fix_scale
  import flt2fix_pkg::*;
(
  input  logic [FLT_W-1:0]       op,
  input  logic signed [SH_W-1:0] fbits,
  output scaled_t                sc
);
  localparam int SIG_W   = MAN_W + 1;
  localparam int BIAS_LS = (1 << (EXP_W - 1)) - 1 + MAN_W;  // exponent of the significand LSB at 1.0
  localparam int HUGE_SH = WORD_W - SIG_W + 1;              // left shift at which any operand overflows

  logic [EXP_W-1:0]       ex;
  logic [MAN_W-1:0]       mn;
  logic [SIG_W-1:0]       sig;
  logic signed [SH_W-1:0] sh;
  logic signed [SH_W-1:0] nsh;
  logic [MAG_W-1:0]       sig_ext;
  logic [MAG_W-1:0]       mask;
  logic [5:0]             amt;

  always_comb begin
    ex      = op[FLT_W-2 -: EXP_W];
    mn      = op[MAN_W-1:0];
    sig     = {(ex != '0), mn};
    sh      = $signed(SH_W'(ex) + SH_W'(ex == '0) - SH_W'(BIAS_LS) + $unsigned(fbits));
    nsh     = -sh;
    sig_ext = MAG_W'(sig);
    amt     = '0;
    mask    = '0;
    sc      = '0;
    sc.sgn  = op[FLT_W-1];
    if (ex == '1) begin
      if (mn != '0) sc.nan  = 1'b1;
      else          sc.huge = 1'b1;
    end else if (sh >= $signed(SH_W'(HUGE_SH))) begin
      sc.huge = 1'b1;
    end else if (sh >= 0) begin
      amt    = sh[5:0];
      sc.mag = sig_ext << amt;
    end else if (nsh >= $signed(SH_W'(SIG_W))) begin
      sc.frac_nz = |sig;
    end else begin
      amt        = nsh[5:0];
      mask       = (MAG_W'(1) << amt) - MAG_W'(1);
      sc.mag     = sig_ext >> amt;
      sc.frac_nz = |(sig_ext & mask);
    end
  end
endmodule

// File: rtl/flt2fix_clamp.sv
`timescale 1ns/1ps
module flt2fix_clamp
  import flt2fix_pkg::*;
(
  input  scaled_t            sc,
  input  logic               sign_sel,
  input  logic               half_sel,
  output logic [WORD_W-1:0]  res,
  output logic               invalid,
  output logic               inexact
);
  logic [MAG_W-1:0]  span;  // 2^N
  logic [MAG_W-1:0]  lim;   // magnitude bound in the direction of the sign
  logic              ovf;
  logic [WORD_W-1:0] m32;

  always_comb begin
    span = half_sel ? (MAG_W'(1) << HALF_W) : (MAG_W'(1) << WORD_W);
    if (sign_sel) lim = sc.sgn ? (span >> 1) : ((span >> 1) - MAG_W'(1));
    else          lim = sc.sgn ? '0 : (span - MAG_W'(1));
    // beyond the bound before truncation: integer part above it, or equal with a fraction
    ovf = sc.huge | (sc.mag > lim) | ((sc.mag == lim) & sc.frac_nz);
    m32 = ovf ? lim[WORD_W-1:0] : sc.mag[WORD_W-1:0];
    if (sc.nan) begin
      res     = '0;
      invalid = 1'b1;
      inexact = 1'b0;
    end else begin
      res     = sc.sgn ? (-m32) : m32;
      invalid = ovf;
      inexact = sc.frac_nz & ~ovf;
    end
  end
endmodule

// File: rtl/flt2fix_unit.sv
`timescale 1ns/1ps
module flt2fix_unit
  import flt2fix_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [FLT_W-1:0]  in_float,
  input  logic              sign_sel,
  input  logic              half_sel,
  input  logic [IMM_W-2:0]  imm_hi,
  input  logic              imm_lo,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_result,
  output logic              out_invalid,
  output logic              out_inexact
);
  logic signed [SH_W-1:0] fbits;
  scaled_t                sc;
  logic [WORD_W-1:0]      c_res;
  logic                   c_inv;
  logic                   c_inx;

  flt2fix_fbits u_fbits (
    .half_sel (half_sel),
    .imm_hi   (imm_hi),
    .imm_lo   (imm_lo),
    .fbits    (fbits)
  );

  flt2fix_scale u_scale (
    .op    (in_float),
    .fbits (fbits),
    .sc    (sc)
  );

  flt2fix_clamp u_clamp (
    .sc       (sc),
    .sign_sel (sign_sel),
    .half_sel (half_sel),
    .res      (c_res),
    .invalid  (c_inv),
    .inexact  (c_inx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_invalid <= 1'b0;
      out_inexact <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result  <= c_res;
        out_invalid <= c_inv;
        out_inexact <= c_inx;
      end
    end
  end

  // R9: one-cycle latency
  p_latency_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R9: no strobe, no valid, result held
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_result) && $stable(out_invalid)));
  // R8: flags never both set
  p_flag_excl_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !(out_invalid && out_inexact));
  // R4: signed half result is sign-extended
  p_half_sext_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && half_sel && sign_sel) |=> (out_result[WORD_W-1:HALF_W] == {(WORD_W-HALF_W){out_result[HALF_W-1]}}));
  // R5: unsigned half result is zero-extended
  p_half_zext_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && half_sel && !sign_sel) |=> (out_result[WORD_W-1:HALF_W] == '0));
  // R7: NaN gives zero and invalid
  p_nan_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (in_float[FLT_W-2 -: EXP_W] == '1) && (in_float[MAN_W-1:0] != '0))
      |=> (out_result == '0 && out_invalid && !out_inexact));
endmodule

// File: tb/flt2fix_unit_bench.sv
`timescale 1ns/1ps
module flt2fix_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_float = '0;
  logic        sign_sel = 1'b0;
  logic        half_sel = 1'b0;
  logic [3:0]  imm_hi = '0;
  logic        imm_lo = 1'b0;
  logic        out_valid;
  logic [31:0] out_result;
  logic        out_invalid;
  logic        out_inexact;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [33:0] q_exp[$];
  string       q_tag[$];
  logic [31:0] last_res = '0;

  flt2fix_unit u_flt2fix_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_float(in_float),
    .sign_sel(sign_sel), .half_sel(half_sel), .imm_hi(imm_hi), .imm_lo(imm_lo),
    .out_valid(out_valid), .out_result(out_result),
    .out_invalid(out_invalid), .out_inexact(out_inexact)
  );

  always #2.5 clk = ~clk;

  function automatic real pow2(input int e);
    real r;
    r = 1.0;
    if (e >= 0) for (int i = 0; i < e; i++) r = r * 2.0;
    else        for (int i = 0; i < -e; i++) r = r / 2.0;
    return r;
  endfunction

  // reference: {result, invalid, inexact}
  function automatic logic [33:0] ref_conv(input logic [31:0] f, input logic sgn,
                                           input logic half, input logic [4:0] imm);
    int n, fb, ex, man;
    real v;
    longint lo, hi, t;
    logic inv, inx;
    n   = half ? 16 : 32;
    fb  = n - int'(imm);
    ex  = int'(f[30:23]);
    man = int'(f[22:0]);
    inv = 1'b0;
    inx = 1'b0;
    if (sgn) begin
      lo = -(longint'(1) << (n - 1));
      hi = (longint'(1) << (n - 1)) - 1;
    end else begin
      lo = 0;
      hi = (longint'(1) << n) - 1;
    end
    if (ex == 255 && man != 0) return {32'h0, 1'b1, 1'b0};
    if (ex == 255)     v = 1.0e300;
    else if (ex == 0)  v = real'(man) * pow2(1 - 150 + fb);
    else               v = real'(man + (1 << 23)) * pow2(ex - 150 + fb);
    if (f[31]) v = -v;
    if (v < real'(lo)) begin
      t = lo; inv = 1'b1;
    end else if (v > real'(hi)) begin
      t = hi; inv = 1'b1;
    end else begin
      t = longint'(v);
      if (v >= 0.0 && real'(t) > v) t = t - 1;
      if (v < 0.0 && real'(t) < v)  t = t + 1;
      inx = (real'(t) != v);
    end
    return {t[31:0], inv, inx};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [33:0] act, input logic [33:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got res=%h inv=%b inx=%b, expected res=%h inv=%b inx=%b",
               tag, act[33:2], act[1], act[0], expv[33:2], expv[1], expv[0]);
    end
  endtask

  task automatic drive(input logic [31:0] f, input logic s, input logic h,
                       input logic [4:0] imm, input string tag);
    logic [33:0] e;
    e = ref_conv(f, s, h, imm);
    @(negedge clk);
    in_float = f; sign_sel = s; half_sel = h;
    imm_hi = imm[4:1]; imm_lo = imm[0]; in_valid = 1'b1;
    q_exp.push_back(e);
    q_tag.push_back(tag);
    last_res = e[33:2];
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor: compare each produced result with the oldest expected item
  always @(negedge clk) begin
    if (!rst && out_valid && !done) begin
      logic [33:0] act, e;
      string tg;
      act = {out_result, out_invalid, out_inexact};
      if (q_exp.size() == 0) begin
        chk(1'b0, "R9 unexpected out_valid", act, 34'h0);
      end else begin
        e  = q_exp.pop_front();
        tg = q_tag.pop_front();
        chk(act === e, tg, act, e);
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({out_valid, out_result, out_invalid, out_inexact} == '0, "R9 reset state",
        {out_result, out_invalid, out_inexact}, 34'h0);

    // half signed, F = 0
    drive(32'h3FC00000, 1, 1, 16, "R2 1.5 truncates to 1");
    drive(32'hBFC00000, 1, 1, 16, "R2 -1.5 truncates to -1");
    drive(32'h46FFFF00, 1, 1, 16, "R6 32767.5 clamps");
    drive(32'hC7000000, 1, 1, 16, "R4 -32768 exact");
    drive(32'h471C4000, 1, 1, 16, "R4 40000 clamps high");
    drive(32'hC71C4000, 1, 1, 16, "R4 -40000 clamps low");
    drive(32'hC2C80000, 1, 1, 8,  "R4 -25600 sign-extended");
    // word signed, F = 1
    drive(32'h3FC00000, 1, 0, 31, "R1 word F=1 gives 3");
    drive(32'h4F000000, 1, 0, 31, "R3 2^32 clamps high");
    drive(32'hCE800000, 1, 0, 31, "R3 -2^31 exact");
    drive(32'hCF000000, 1, 0, 31, "R3 -2^32 clamps low");
    // word unsigned
    drive(32'hBE800000, 0, 0, 31, "R5 -0.5 gives 0 invalid");
    drive(32'h80000000, 0, 0, 31, "R5 negative zero");
    drive(32'h4F000000, 0, 0, 31, "R5 2^32 clamps to max");
    drive(32'h4E6E6B28, 0, 0, 31, "R5 2e9 in range");
    // half unsigned, F = 8
    drive(32'h42C80000, 0, 1, 8, "R1 half F=8");
    drive(32'h43960000, 0, 1, 8, "R5 76800 clamps to 65535");
    drive(32'hBF800000, 0, 1, 8, "R5 half negative");
    // specials
    drive(32'h7FC00000, 1, 0, 31, "R7 NaN");
    drive(32'h7F800000, 1, 0, 31, "R7 +inf word signed");
    drive(32'hFF800000, 1, 1, 16, "R7 -inf half signed");
    drive(32'hFF800000, 0, 0, 0,  "R7 -inf unsigned");
    // fraction-count extremes
    drive(32'h3F000000, 1, 0, 0,  "R1 F=32 signed clamps");
    drive(32'h3F000000, 0, 0, 0,  "R1 F=32 unsigned 2^31");
    drive(32'h42C80000, 1, 1, 20, "R1 F=-4 gives 6");
    drive(32'h00000001, 1, 0, 0,  "R2 denormal inexact");
    drive(32'h0DA24260, 1, 0, 0,  "R2 tiny inexact");
    // flags cleared between conversions
    drive(32'h7FC00000, 1, 1, 16, "R8 NaN before exact");
    drive(32'h3F800000, 1, 1, 16, "R8 exact after NaN");
    drive(32'h3FC00000, 1, 1, 16, "R8 inexact after exact");
    drive(32'h3F800000, 1, 1, 16, "R8 exact after inexact");
    idle(2);

    // R9: inputs without strobe are ignored
    in_float = 32'h7FC00000; sign_sel = 1'b0; half_sel = 1'b0;
    imm_hi = 4'h0; imm_lo = 1'b0;
    repeat (3) @(negedge clk);
    chk(!out_valid && out_result == last_res && !out_invalid && !out_inexact,
        "R9 hold without strobe", {out_result, out_invalid, out_inexact}, {last_res, 2'b00});

    idle(3);
    chk(q_exp.size() == 0, "R9 all results delivered",
        34'(q_exp.size()), 34'h0);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL R9 watchdog expired: got running, expected finished");
      summary();
      $finish;
    end
  end
endmodule